// File: doc/BRIEF.md
# Gated-Clock Eight-Stage Shift Register

This block is an eight-stage register with one serial output. Each time it is clocked, it either shifts one bit in from a serial input or takes a whole byte from eight parallel inputs. A mode input picks between the two. Two gate inputs are combined in NOR fashion to form an effective clock. One gate input can run freely as a clock while the other stops the register on command. Driving either gate input high stalls the register.

Both gate inputs are asynchronous to the system clock. They pass through a two-flop synchronizer, and the register acts on a 0-to-1 change of the synchronized NOR value. Mode, serial data and parallel data are sampled in the system-clock cycle in which that change is taken. They must stay steady from the gate change until three system-clock edges later. An active-low clear zeroes the register at once and holds it at zero. The release of the clear is synchronized.

Top module: `nor_gated_shifter`

## Requirements
- R1: With `shift_mode_i` = 1, each effective clock edge moves stage k into stage k+1 and loads `ser_i` into stage 0. `ser_o` always shows stage 7.
- R2: With `shift_mode_i` = 0, an effective clock edge loads `par_i` into the register, with bit 0 going to stage 0 and bit 7 to stage 7. Nothing is loaded before that edge.
- R3: During a parallel load, `ser_i` has no effect on the register contents.
- R4: The effective clock is NOR(`gate_a_i`, `gate_b_i`). The register changes only when that value rises from 0 to 1. While either input is high, the register holds.
- R5: The two gate inputs play the same role. With one held low, the other clocks the register on its high-to-low transition.
- R6: `clr_n_i` low zeroes all stages at once, without waiting for the system clock. While it stays low, it overrides the mode, the data and the gate inputs.
- R7: A gate change made just after a system-clock edge appears at the register on the third rising system-clock edge after the change, and not before.
- R8: After `clr_n_i` is released, a NOR value that was already 1 at release causes no update. Only a fresh 0-to-1 rise clocks the register.
- R9: Raising the gate input that acts as an inhibit while the clocking gate input is high produces no extra clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| clr_n_i | input | 1 | Asynchronous active-low clear |
| shift_mode_i | input | 1 | 1 = serial shift, 0 = parallel load |
| ser_i | input | 1 | Serial data into stage 0 |
| par_i | input | 8 | Parallel load data, bit 0 goes to stage 0 |
| gate_a_i | input | 1 | Gate input A, NOR-combined with B |
| gate_b_i | input | 1 | Gate input B, NOR-combined with A |
| ser_o | output | 1 | Value of stage 7 |

## Verification
A wrong stage value reaches `ser_o` no later than seven shifts after it is formed. The bench therefore loads every byte value and shifts each one fully out with known serial data, which exposes both bit-order and data-path faults. A spurious or missing edge shows up as a one-bit slip in the bit stream that follows. The inhibit, clear-release and latency cases are placed so that such a slip appears within the next eight pulses.

// File: rtl/nor_gated_shifter.sv
module nor_gated_shifter #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             clr_n_i,
  input  logic             shift_mode_i,
  input  logic             ser_i,
  input  logic [WIDTH-1:0] par_i,
  input  logic             gate_a_i,
  input  logic             gate_b_i,
  output logic             ser_o
);

  logic [SYNC_STAGES-1:0] sync_a_q, sync_b_q, arm_q;
  logic [WIDTH-1:0]       stage_q;
  logic                   nor_prev_q;
  logic                   nor_now, fire;

  always_ff @(posedge clk_i) begin
    sync_a_q <= {sync_a_q[SYNC_STAGES-2:0], gate_a_i};
    sync_b_q <= {sync_b_q[SYNC_STAGES-2:0], gate_b_i};
  end

  assign nor_now = ~(sync_a_q[SYNC_STAGES-1] | sync_b_q[SYNC_STAGES-1]);
  assign fire    = arm_q[SYNC_STAGES-1] & nor_now & ~nor_prev_q;

  always_ff @(posedge clk_i or negedge clr_n_i) begin
    if (!clr_n_i) begin
      arm_q      <= '0;
      nor_prev_q <= 1'b1;
      stage_q    <= '0;
    end else begin
      arm_q      <= {arm_q[SYNC_STAGES-2:0], 1'b1};
      nor_prev_q <= nor_now;
      if (fire)
        stage_q <= shift_mode_i ? {stage_q[WIDTH-2:0], ser_i} : par_i;
    end
  end

  assign ser_o = stage_q[WIDTH-1];

  always_ff @(posedge clk_i) begin
    if (!clr_n_i) AST_CLEAR_ZERO: assert (stage_q == '0); // R6
  end

  AST_HOLD_NO_EDGE: assert property (@(posedge clk_i) disable iff (!clr_n_i)
    !fire |=> $stable(stage_q)); // R4

  AST_SHIFT_MOVE: assert property (@(posedge clk_i) disable iff (!clr_n_i)
    fire && shift_mode_i |=> stage_q == {$past(stage_q[WIDTH-2:0]), $past(ser_i)}); // R1

  AST_LOAD_BYTE: assert property (@(posedge clk_i) disable iff (!clr_n_i)
    fire && !shift_mode_i |=> stage_q == $past(par_i)); // R2

  AST_NO_EDGE_UNARMED: assert property (@(posedge clk_i) disable iff (!clr_n_i)
    !arm_q[SYNC_STAGES-1] |=> $stable(stage_q)); // R8

endmodule

// File: tb/nor_gated_shifter_tb.sv
`timescale 1ns/1ps
module nor_gated_shifter_tb;
  logic clk = 0, clr_n = 0, mode = 1, ser = 0, ga = 1, gb = 1, live = 0;
  logic [7:0] par = '0, model = '0;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  nor_gated_shifter u_dut (.clk_i(clk), .clr_n_i(clr_n), .shift_mode_i(mode),
    .ser_i(ser), .par_i(par), .gate_a_i(ga), .gate_b_i(gb), .ser_o(u_q));
  logic u_q;

  task automatic check(string req, logic exp);
    n_chk++;
    if (u_q !== exp) begin
      n_fail++;
      $display("FAIL %s: ser_o=%b expected %b", req, u_q, exp);
    end
  endtask

  task automatic gate(logic a, logic b);
    logic was;
    was = ~(ga | gb);
    ga = a; gb = b;
    repeat (4) @(negedge clk);
    if (live && !was && ~(a | b))
      model = mode ? {model[6:0], ser} : par;
  endtask

  task automatic pulse_a();
    gate(1, gb); gate(0, gb);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R6 reset", 1'b0);
    clr_n = 1; gb = 0;
    repeat (6) @(negedge clk);
    live = 1;

    for (int v = 0; v < 256; v++) begin
      mode = 0; par = v[7:0]; ser = v[0];
      pulse_a();
      check("R2/R3 load", model[7]);
      mode = 1;
      for (int k = 0; k < 8; k++) begin
        ser = ~v[k]; par = ~v[7:0];
        pulse_a();
        check("R1 shift", model[7]);
      end
    end

    // R7: latency of three system edges
    mode = 0; par = 8'h80; gate(1, 0);
    ga = 0;
    @(negedge clk); @(negedge clk);
    check("R7 not before third edge", 1'b0);
    @(negedge clk);
    check("R7 at third edge", 1'b1);
    model = 8'h80;
    @(negedge clk);

    // R5: gate B as clock, A held low
    mode = 0; par = 8'h01;
    gate(0, 1); gate(0, 0);
    check("R5 load via B", model[7]);
    mode = 1; ser = 0;
    for (int k = 0; k < 7; k++) begin gate(0, 1); gate(0, 0); end
    check("R5 shift via B", 1'b1);

    // R9: inhibit B raised while clock A high, then A lowered
    gate(1, 0); gate(1, 1); gate(0, 1);
    check("R9 no extra shift", model[7]);
    check("R4 held while inhibited", 1'b1);
    gate(0, 0);
    check("R4 edge on inhibit release", model[7]);

    // R6: asynchronous clear overrides everything
    mode = 0; par = 8'hFF; gate(1, 0); gate(0, 0);
    check("R2 load ones", 1'b1);
    #1 clr_n = 0; #0.5;
    check("R6 immediate clear", 1'b0);
    live = 0;
    gate(1, 0); gate(0, 0);
    check("R6 clear beats clock", 1'b0);

    // R8: release with NOR already 1, serial 1 present
    mode = 1; ser = 1;
    @(negedge clk); clr_n = 1;
    model = '0;
    repeat (6) @(negedge clk);
    live = 1;
    check("R8 no update at release", 1'b0);
    ser = 0;
    for (int k = 0; k < 8; k++) begin
      pulse_a();
      check("R8 no stray bit", model[7]);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule